// File: doc/BRIEF.md
# Marker-framed byte stream decoder

This block sits behind a serial receiver and turns a flat stream of bytes into framed packet bytes. Framing travels in-band. Reserved marker values open a packet, flag the last byte, and announce a channel number. An escape marker lets the payload carry any of those reserved values. The decoder strips every marker and undoes the escapes. It then presents each payload byte on a valid/ready source, with start-of-packet and end-of-packet flags on the right bytes.

The closing marker is sent one byte early: it comes just before the final payload byte, not after it. Because of this, every flag is known when its byte arrives, and the decoder never has to hold a byte back to look ahead. Idle fill is assumed to be removed upstream. Only channel zero is accepted. A violation of the framing rules raises a one-cycle error pulse and discards the rest of the packet.

Top module: `byte_pkt_decoder`

## Requirements
- R1: While reset is held and in the cycle after its release, `out_valid` and `err` are low. With the output empty, `in_ready` is high.
- R2: Outside a packet, every byte other than the start marker 0x7a is discarded, and no output is produced.
- R3: A non-marker byte inside a packet is output unchanged. The first such byte after a start marker carries `out_sop`=1.
- R4: After the escape marker 0x7d, the next byte is output XORed with 0x20 as ordinary data, for example 0x5a gives 0x7a and 0x5d gives 0x7d. An escape may appear after an end marker.
- R5: The end marker 0x7b emits nothing itself. The next data byte is output with `out_eop`=1 and closes the packet, so later bytes are discarded until a start marker arrives.
- R6: A packet with one payload byte (0x7a, 0x7b, d) outputs d with `out_sop` and `out_eop` both set.
- R7: The channel marker 0x7c followed by 0x00 is consumed without producing output, and the packet continues.
- R8: A channel byte other than 0x00 gives an error: `err` goes high for one cycle, the packet is dropped, and bytes are ignored until the next 0x7a. `out_valid` is low whenever `err` is high.
- R9: A start marker inside a packet restarts it. Pending escape, end and channel state is cleared, and the next data byte carries `out_sop`=1.
- R10: Each of the following raises a one-cycle `err` pulse and drops the packet: escape followed by escape; escape followed by an end or channel marker; end followed by an end or channel marker.
- R11: While `out_valid`=1 and `out_ready`=0, `in_ready` is low and `out_data`, `out_sop` and `out_eop` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| out_data | output | 8 | Decoded payload byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Sink accepts the payload byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| err | output | 1 | One-cycle protocol-violation pulse |

## Verification
The stream patterns are:
- leading garbage before the first packet, which separates discarding from passing bytes through;
- plain multi-byte packets and a one-byte packet, which separate the start and end flag placement from the data path;
- escaped payload values that equal marker codes, which show whether the XOR is applied and whether the escaped value is mistaken for a marker;
- channel sequences with a zero and a nonzero number, mid-packet restarts, and each illegal marker pairing, which together separate state clearing from error reporting;
- a long packet under a pseudo-random output stall, which exposes lost or altered bytes under backpressure.

// File: rtl/byte_pkt_decoder.sv
module byte_pkt_decoder #(
  parameter logic [7:0] SOP_CODE    = 8'h7a,
  parameter logic [7:0] EOP_CODE    = 8'h7b,
  parameter logic [7:0] CHN_CODE    = 8'h7c,
  parameter logic [7:0] ESC_CODE    = 8'h7d,
  parameter logic [7:0] FLIP_MASK   = 8'h20,
  parameter logic [7:0] CHN_ALLOWED = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_sop,
  output logic       out_eop,
  output logic       err
);

  logic in_pkt, esc_q, end_q, chn_q, first_q;
  logic n_pkt, n_esc, n_end, n_chn, n_first;
  logic emit, fault;
  logic [7:0] emit_data;

  wire take = in_valid && in_ready;

  assign in_ready  = !out_valid || out_ready;
  assign emit_data = esc_q ? (in_data ^ FLIP_MASK) : in_data;

  always_comb begin
    n_pkt   = in_pkt;
    n_esc   = esc_q;
    n_end   = end_q;
    n_chn   = chn_q;
    n_first = first_q;
    emit    = 1'b0;
    fault   = 1'b0;
    if (take) begin
      if (!in_pkt) begin
        if (in_data == SOP_CODE) begin
          n_pkt   = 1'b1;
          n_esc   = 1'b0;
          n_end   = 1'b0;
          n_chn   = 1'b0;
          n_first = 1'b1;
        end
      end else if (chn_q) begin
        n_chn = 1'b0;
        if (in_data != CHN_ALLOWED) fault = 1'b1;
      end else if (in_data == SOP_CODE) begin
        n_esc   = 1'b0;
        n_end   = 1'b0;
        n_chn   = 1'b0;
        n_first = 1'b1;
      end else if (in_data == EOP_CODE) begin
        if (esc_q || end_q) fault = 1'b1;
        else n_end = 1'b1;
      end else if (in_data == CHN_CODE) begin
        if (esc_q || end_q) fault = 1'b1;
        else n_chn = 1'b1;
      end else if (in_data == ESC_CODE) begin
        if (esc_q) fault = 1'b1;
        else n_esc = 1'b1;
      end else begin
        emit    = 1'b1;
        n_esc   = 1'b0;
        n_first = 1'b0;
        if (end_q) begin
          n_pkt = 1'b0;
          n_end = 1'b0;
        end
      end
      if (fault) begin
        n_pkt   = 1'b0;
        n_esc   = 1'b0;
        n_end   = 1'b0;
        n_chn   = 1'b0;
        n_first = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt  <= 1'b0;
      esc_q   <= 1'b0;
      end_q   <= 1'b0;
      chn_q   <= 1'b0;
      first_q <= 1'b0;
      err     <= 1'b0;
    end else begin
      in_pkt  <= n_pkt;
      esc_q   <= n_esc;
      end_q   <= n_end;
      chn_q   <= n_chn;
      first_q <= n_first;
      err     <= fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= emit_data;
      out_sop   <= first_q;
      out_eop   <= end_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/byte_pkt_decoder_chk.sv
module byte_pkt_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_sop,
  input logic       out_eop,
  input logic       err
);

  logic need_sop;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) need_sop <= 1'b1;
    else if (err) need_sop <= 1'b1;
    else if (out_valid && out_ready) need_sop <= out_eop;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !err));

  assert_first_has_sop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && need_sop) |-> out_sop);

  assert_err_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

endmodule

bind byte_pkt_decoder byte_pkt_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
  .out_eop(out_eop), .err(err)
);

// File: tb/sim_byte_pkt_decoder.sv
`timescale 1ns/1ps
module sim_byte_pkt_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_sop, out_eop, err;

  always #4 clk = ~clk;

  byte_pkt_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  int err_exp = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  logic bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h5b;
  logic done = 1'b0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic expect_item(input logic [7:0] d, input logic s, input logic e, input string req);
    exp_q.push_back({s, e, d});
    tag_q.push_back(req);
  endtask

  task automatic send(input logic [7:0] b);
    logic acc;
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    forever begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_err(input string req);
    repeat (4) @(negedge clk);
    checks++;
    if (err_seen != err_exp) fail(req, "error pulse count", err_seen, err_exp);
  endtask

  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0];
    end else begin
      out_ready = 1'b1;
    end
  end

  logic prev_stall = 1'b0;
  logic prev_err = 1'b0;
  logic [9:0] prev_out = '0;
  always @(negedge clk) begin
    logic [9:0] e;
    string t;
    #2;
    if (rst_n) begin
      if (err) err_seen++;
      if (prev_err && err) begin
        checks++;
        fail("R10", "err longer than one cycle", 1, 0);
      end
      if (prev_stall) begin
        checks++;
        if (!out_valid || {out_sop, out_eop, out_data} != prev_out)
          fail("R11", "output changed while stalled", {out_valid, out_sop, out_eop, out_data}, {1'b1, prev_out});
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fail("R2", "unexpected output byte", {out_sop, out_eop, out_data}, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({out_sop, out_eop, out_data} != e)
            fail(t, "sop,eop,data", {out_sop, out_eop, out_data}, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_sop, out_eop, out_data};
      prev_err   = err;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || err !== 1'b0) fail("R1", "outputs in reset", {out_valid, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || err !== 1'b0 || in_ready !== 1'b1)
      fail("R1", "state after reset", {out_valid, err, in_ready}, 1);

    // R2 garbage, R3 data with sop, R5 end marker
    send(8'h11); send(8'h22); send(8'h7b); send(8'h33);
    expect_item(8'h41, 1, 0, "R3");
    expect_item(8'h42, 0, 0, "R3");
    expect_item(8'h43, 0, 1, "R5");
    send(8'h7a); send(8'h41); send(8'h42); send(8'h7b); send(8'h43);

    // R5 bytes after close discarded, R6 one-byte packet
    send(8'h55); send(8'h66);
    expect_item(8'h99, 1, 1, "R6");
    send(8'h7a); send(8'h7b); send(8'h99);

    // R4 escapes, including after an end marker
    expect_item(8'h7a, 1, 0, "R4");
    expect_item(8'h7d, 0, 0, "R4");
    expect_item(8'h10, 0, 0, "R4");
    expect_item(8'h7b, 0, 1, "R4");
    send(8'h7a); send(8'h7d); send(8'h5a); send(8'h7d); send(8'h5d);
    send(8'h10); send(8'h7b); send(8'h7d); send(8'h5b);

    // R7 channel zero consumed
    expect_item(8'h01, 1, 0, "R7");
    expect_item(8'h02, 0, 1, "R7");
    send(8'h7a); send(8'h7c); send(8'h00); send(8'h01); send(8'h7b); send(8'h02);
    check_err("R7");

    // R8 nonzero channel
    expect_item(8'h05, 1, 0, "R8");
    send(8'h7a); send(8'h05); send(8'h7c); send(8'h03); err_exp++;
    send(8'h06);
    check_err("R8");
    expect_item(8'h07, 1, 0, "R8");
    expect_item(8'h08, 0, 1, "R8");
    send(8'h7a); send(8'h07); send(8'h7b); send(8'h08);

    // R9 restart clears escape and end state
    expect_item(8'h01, 1, 0, "R9");
    expect_item(8'h02, 1, 0, "R9");
    expect_item(8'h03, 1, 0, "R9");
    expect_item(8'h04, 0, 1, "R9");
    send(8'h7a); send(8'h01); send(8'h7d); send(8'h7a); send(8'h02);
    send(8'h7b); send(8'h7a); send(8'h03); send(8'h7b); send(8'h04);
    check_err("R9");

    // R10 illegal pairings
    send(8'h7a); send(8'h7d); send(8'h7d); err_exp++; send(8'h09);
    check_err("R10");
    send(8'h7a); send(8'h7d); send(8'h7b); err_exp++;
    check_err("R10");
    send(8'h7a); send(8'h7b); send(8'h7b); err_exp++;
    check_err("R10");
    send(8'h7a); send(8'h7b); send(8'h7c); err_exp++;
    check_err("R10");
    send(8'h7a); send(8'h7d); send(8'h7c); err_exp++;
    check_err("R10");

    // R11 backpressure
    bp_mode = 1'b1;
    send(8'h7a);
    for (int i = 0; i < 24; i++) begin
      expect_item(8'h30 + i[7:0], (i == 0), 0, "R11");
      send(8'h30 + i[7:0]);
    end
    expect_item(8'h6f, 0, 1, "R11");
    send(8'h7b); send(8'h6f);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) fail("R11", "items never produced", exp_q.size(), 0);
    check_err("R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule